// File: doc/BRIEF.md
# Reset and Wake Start-up Sequencer

This block keeps the processor core stalled after a power-on reset, or after a wake from a deep sleep state, until its clocks can be trusted. Its output `run_en_o` is the single permission the core needs to start fetching. When reset is released, the block first waits for a power settling delay. That delay is timed by a free-running watchdog oscillator clock that is separate from the system clock. The block then runs an oscillator stabilisation count on the selected system clock, and only after that count does it raise `run_en_o`.

A wake from deep sleep takes a shorter path. The supply is already stable, so only the oscillator stabilisation count runs. The length of that count depends on the class of the selected clock source and on a 2-bit start-up select. The source class is decoded from a 4-bit clock-select code. The settling-done flag is produced in the watchdog clock domain. It passes through a two-flop synchroniser before the system-clock count may begin.

The analog oscillators, the storage of the configuration fuses and the sleep controller are outside this block. Their results arrive as plain inputs.

Top module: `startup_seq`

## Requirements
- R1: The clock-select code `csel_i` decodes to a source class. Code 0000 is an external clock. Codes 0001 to 0100 are the calibrated internal RC. Codes 0101 to 1000 are an external RC. Code 1001 is an external low-frequency crystal. Codes 1010 to 1111 are a crystal or resonator.
- R2: The stabilisation count lasts 2^k cycles of `clk_i`, where k = OSC_LOG2_BASE + c + s. The class term c is 0 for an external clock, 2 for the internal RC, 2 for an external RC, 4 for a crystal and 5 for a low-frequency crystal. The start-up select term s is 0 for `sut_i`=00, 1 for 01, 2 for 11 and 3 for 10, so 10 is the longest.
- R3: After `rst_ni` rises, the settling delay lasts SHORT_DLY cycles of `wdt_clk_i` (default 4096) when `long_dly_i`=0, and LONG_DLY cycles (default 65536) when `long_dly_i`=1. `run_en_o` stays low for the whole delay.
- R4: The settling-done flag passes through a two-flop synchroniser into the `clk_i` domain. The stabilisation count starts only after the synchronised flag is seen. `run_en_o` is high within 3 + 2^k cycles of `clk_i` after the delay ends.
- R5: `run_en_o` is low through both phases. It rises in the cycle the stabilisation count reaches terminal. After a wake sampled at a `clk_i` edge, `run_en_o` is low for exactly 2^k cycles.
- R6: When `wake_i` is sampled high while `run_en_o` is high, `run_en_o` drops and only the stabilisation count runs. No settling delay runs on this path.
- R7: `wake_i` has no effect while either phase is in progress. It neither restarts nor shortens the sequence.
- R8: `rst_ni` low clears `run_en_o` at once in any phase. Its release restarts the sequence from the settling delay.
- R9: `csel_i` and `sut_i` are sampled when the stabilisation count starts. Changes to them during the count do not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Selected system clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wdt_clk_i | input | 1 | Free-running watchdog oscillator clock |
| wake_i | input | 1 | Wake request from deep sleep, `clk_i` domain |
| csel_i | input | 4 | Clock-select code |
| sut_i | input | 2 | Start-up time select |
| long_dly_i | input | 1 | Settling delay select: 0 short, 1 long |
| run_en_o | output | 1 | Core run enable |

## Verification
A count that is wrong by one, or a start-up table entry that is wrong, shows up at the port. The wake path sets exactly how many `clk_i` cycles `run_en_o` stays low, so the error appears in the first wake that uses the affected select codes. A state machine that skips the settling phase, or that lets a wake or a select change act during a phase, shows up as an early rise of `run_en_o`. That rise comes well before the watchdog-clock boundary, or before the expected cycle count. A settling counter that never finishes shows up as `run_en_o` still low a few cycles after the delay should have ended.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  typedef enum logic [2:0] {
    SRC_EXT_CLK,
    SRC_INT_RC,
    SRC_EXT_RC,
    SRC_LF_XTAL,
    SRC_XTAL
  } src_class_e;

  typedef enum logic [1:0] {
    ST_SETTLE,
    ST_STAB,
    ST_RUN
  } seq_state_e;

  function automatic src_class_e decode_src(input logic [3:0] code);
    if (code == 4'd0)       return SRC_EXT_CLK;
    else if (code <= 4'd4)  return SRC_INT_RC;
    else if (code <= 4'd8)  return SRC_EXT_RC;
    else if (code == 4'd9)  return SRC_LF_XTAL;
    else                    return SRC_XTAL;
  endfunction

  function automatic logic [2:0] class_log2(input src_class_e cls);
    case (cls)
      SRC_EXT_CLK: return 3'd0;
      SRC_INT_RC:  return 3'd2;
      SRC_EXT_RC:  return 3'd2;
      SRC_XTAL:    return 3'd4;
      SRC_LF_XTAL: return 3'd5;
      default:     return 3'd5;
    endcase
  endfunction

  // 10 is the longest start-up setting
  function automatic logic [1:0] sut_log2(input logic [1:0] sut);
    case (sut)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SHORT_DLY = 4096,
  parameter int LONG_DLY  = 65536
) (
  input  logic wdt_clk_i,
  input  logic rst_ni,
  input  logic long_dly_i,
  output logic done_o
);
  localparam int CNT_W = (LONG_DLY > SHORT_DLY) ? $clog2(LONG_DLY) : $clog2(SHORT_DLY);
  localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_TERM  = CNT_W'(LONG_DLY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             done_q;

  assign term = long_dly_i ? LONG_TERM : SHORT_TERM;

  always_ff @(posedge wdt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == term) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  p_done_sticky_r3: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  p_cnt_bound_r3: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    (!done_q && !$past(done_q)) |-> ($past(cnt_q) <= term));

endmodule

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/stab_seq.sv
module stab_seq
  import startup_seq_pkg::*;
#(
  parameter int OSC_LOG2_BASE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       settled_i,
  input  logic       wake_i,
  input  logic [3:0] csel_i,
  input  logic [1:0] sut_i,
  output logic       run_en_o
);
  localparam int CNT_W = OSC_LOG2_BASE + 5 + 3;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_q, term_d;
  logic [CNT_W-1:0] term_sel;
  logic [7:0]       k_sel;

  always_comb begin
    k_sel    = 8'(OSC_LOG2_BASE) + 8'(class_log2(decode_src(csel_i))) + 8'(sut_log2(sut_i));
    term_sel = ~({CNT_W{1'b1}} << k_sel);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    term_d  = term_q;
    case (state_q)
      ST_SETTLE: if (settled_i) begin
        state_d = ST_STAB;
        cnt_d   = '0;
        term_d  = term_sel;
      end
      ST_STAB: begin
        if (cnt_q == term_q) state_d = ST_RUN;
        else                 cnt_d   = cnt_q + 1'b1;
      end
      ST_RUN: if (wake_i) begin
        state_d = ST_STAB;
        cnt_d   = '0;
        term_d  = term_sel;
      end
      default: state_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETTLE;
      cnt_q   <= '0;
      term_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      term_q  <= term_d;
    end
  end

  assign run_en_o = (state_q == ST_RUN);

  p_count_after_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAB && $past(state_q) == ST_SETTLE) |-> $past(settled_i));

  p_rise_at_terminal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> ($past(state_q) == ST_STAB && $past(cnt_q) == $past(term_q)));

  p_wake_skips_settle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && wake_i) |=> (state_q == ST_STAB && cnt_q == '0));

  p_term_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAB && $past(state_q) == ST_STAB) |-> $stable(term_q));

endmodule

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int SHORT_DLY     = 4096,
  parameter int LONG_DLY      = 65536,
  parameter int OSC_LOG2_BASE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdt_clk_i,
  input  logic       wake_i,
  input  logic [3:0] csel_i,
  input  logic [1:0] sut_i,
  input  logic       long_dly_i,
  output logic       run_en_o
);
  logic settle_done_wdt;
  logic settle_done_sys;

  settle_timer #(
    .SHORT_DLY (SHORT_DLY),
    .LONG_DLY  (LONG_DLY)
  ) u_settle (
    .wdt_clk_i  (wdt_clk_i),
    .rst_ni     (rst_ni),
    .long_dly_i (long_dly_i),
    .done_o     (settle_done_wdt)
  );

  sync_2ff #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (settle_done_wdt),
    .q_o    (settle_done_sys)
  );

  stab_seq #(.OSC_LOG2_BASE(OSC_LOG2_BASE)) u_stab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .settled_i (settle_done_sys),
    .wake_i    (wake_i),
    .csel_i    (csel_i),
    .sut_i     (sut_i),
    .run_en_o  (run_en_o)
  );

  p_reset_clears_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settle_done_sys |-> !run_en_o);

endmodule

// File: tb/startup_seq_tb.sv
`timescale 1ns/1ps
module startup_seq_tb;
  localparam int SHORT = 16;
  localparam int LONG  = 48;
  localparam int BASE  = 1;
  localparam real TW   = 14.0;
  localparam int NV    = 11;

  localparam logic [3:0] V_CSEL [NV] = '{4'h0, 4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'h9, 4'hA, 4'hF, 4'h3};
  localparam logic [1:0] V_SUT  [NV] = '{2'b00, 2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b00, 2'b10, 2'b01, 2'b11, 2'b10};
  localparam int         V_N    [NV] = '{2, 16, 8, 16, 32, 8, 64, 512, 64, 128, 64};

  logic clk = 1'b0, wdt_clk = 1'b0, rst_n = 1'b0, wake = 1'b0, long_dly = 1'b0;
  logic [3:0] csel = 4'h0;
  logic [1:0] sut = 2'b00;
  logic run_en;
  int n_run = 0, n_fail = 0;
  realtime t0;

  always #2.5 clk = ~clk;
  always #7 wdt_clk = ~wdt_clk;

  startup_seq #(.SHORT_DLY(SHORT), .LONG_DLY(LONG), .OSC_LOG2_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wdt_clk_i(wdt_clk), .wake_i(wake),
    .csel_i(csel), .sut_i(sut), .long_dly_i(long_dly), .run_en_o(run_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // wake at a posedge, count negedges with run_en low; optional poke mid-count
  task automatic measure(input int poke_at, input bit poke_csel, output int lows);
    lows = 0;
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (run_en) break;
      lows++;
      if (lows == poke_at) begin
        if (poke_csel) begin csel = 4'hF; sut = 2'b11; end
        else wake = 1'b1;
      end
      if (lows == poke_at + 1) wake = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic release_rst();
    @(negedge clk); rst_n = 1'b1; t0 = $realtime;
  endtask

  task automatic check_settle(input string req, input int dly);
    #(t0 + (dly - 1) * TW - 1.0 - $realtime);
    chk({req, " low before delay end"}, run_en, 0);
    #(t0 + dly * TW + 40.0 - $realtime);
    chk({req, " high after delay plus count"}, run_en, 1);
  endtask

  initial begin
    int lows;
    repeat (4) @(negedge clk);
    chk("R8 reset state", run_en, 0);
    release_rst();
    check_settle("R3 short", SHORT);

    // R1 R2 R5 R6: table of codes, wake path, exact low length
    for (int i = 0; i < NV; i++) begin
      csel = V_CSEL[i]; sut = V_SUT[i];
      measure(-5, 1'b0, lows);
      chk($sformatf("R1/R2/R5/R6 csel=%b sut=%b", V_CSEL[i], V_SUT[i]), lows, V_N[i]);
    end

    // R7 second wake during count
    csel = 4'h1; sut = 2'b10;
    measure(10, 1'b0, lows);
    chk("R7 wake during count ignored", lows, 64);

    // R9 select change during count
    csel = 4'h1; sut = 2'b00;
    measure(3, 1'b1, lows);
    chk("R9 select sampled at start", lows, 8);

    // R7 wake during settle phase
    @(negedge clk); rst_n = 1'b0; csel = 4'h0; sut = 2'b00;
    @(negedge clk);
    chk("R8 reset clears run", run_en, 0);
    release_rst();
    repeat (4) @(negedge clk);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    check_settle("R7 wake in settle", SHORT);

    // R8 reset during stabilisation count
    csel = 4'h9; sut = 2'b10;
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 in count low", run_en, 0);
    rst_n = 1'b0; csel = 4'h0; sut = 2'b00;
    repeat (3) @(negedge clk);
    chk("R8 held in reset", run_en, 0);
    release_rst();
    check_settle("R8 restart", SHORT);

    // R3 R4 long delay
    @(negedge clk); rst_n = 1'b0; long_dly = 1'b1;
    repeat (3) @(negedge clk);
    release_rst();
    #(t0 + (SHORT + 4) * TW - $realtime);
    chk("R3 long past short boundary low", run_en, 0);
    check_settle("R3/R4 long", LONG);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule